// File: doc/BRIEF.md
# Serial Character Transmitter with Flow Control and Break

This block turns bytes into asynchronous serial characters on a single output line. The frame format is chosen at run time by a 31-bit setup word. The word sets the clocks per bit, the number of data bits (5 to 8), parity (off, even, odd, forced 0 or forced 1), and one or two stop bits. A producer offers a byte with a strobe. The byte is taken on the cycle the strobe is high and `busy` is low. `busy` then stays high until the last stop bit has been sent.

An active-low clear-to-send input can hold back the start of new characters. One setup bit turns this gating off. A break request pulls the line low for as long as it is held. When break is released, the line returns high for at least one full bit time before the block can accept another byte.

Setup word layout:

| Bits | Meaning |
|------|---------|
| [23:0] | Clocks per bit |
| 24 | Parity select |
| 25 | Forced parity |
| 26 | Parity enable |
| 27 | Two stop bits |
| [29:28] | Length code |
| 30 | Flow-control disable |

Top module: `serial_tx`

## Requirements
- R1: A byte is accepted on a rising clock edge where `send_req` is high and `busy` is low. `busy` is high from the next cycle until the final stop bit has lasted its full bit time. In that next cycle `busy` is low again, provided no break and no flow hold is present.
- R2: When `cfg_word[30]` is 0 and `cts_n` has been high for three consecutive cycles, `busy` is high and no new character starts.
- R3: When `cfg_word[30]` is 1, the level of `cts_n` has no effect: characters are accepted and sent while `cts_n` is high.
- R4: While `brk_req` is high, `line_out` is low from the cycle after it is first sampled high. This aborts any character in progress. `busy` stays high throughout.
- R5: When idle, `line_out` is high. A character is a low start bit, followed by the data bits least-significant first. The number of data bits is 8 minus `cfg_word[29:28]`.
- R6: When `cfg_word[26]` is 1, one parity bit follows the data bits, and its value depends on `cfg_word[25]`:
  - `cfg_word[25]` is 0: the parity bit makes the count of ones in the data bits plus the parity bit even when `cfg_word[24]` is 0, and odd when `cfg_word[24]` is 1.
  - `cfg_word[25]` is 1: the parity bit equals `cfg_word[24]`.
- R7: The frame ends with high stop bits: one when `cfg_word[27]` is 0, two when it is 1.
- R8: Every bit lasts `cfg_word[23:0]` clock cycles. A value of 0 is treated as 1.
- R9: A character already started always completes unchanged, even if `cts_n` rises during it.
- R10: After `brk_req` falls, `line_out` is high and `busy` is high for exactly one bit time, measured in clock cycles of the current setup. After that the block is idle.
- R11: The frame format and bit time are captured when the byte is accepted. Changing `cfg_word` during a character does not alter that character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 31 | Run-time setup word (layout above) |
| send_req | input | 1 | Byte strobe |
| send_byte | input | 8 | Byte to send, valid with `send_req` |
| cts_n | input | 1 | Active-low clear-to-send from the far end |
| brk_req | input | 1 | Hold the line low while high |
| busy | output | 1 | High while a byte cannot be accepted |
| line_out | output | 1 | Serial output, idle high |

## Verification
The bound checker checks the following on every cycle:
- a start bit follows each accepted byte;
- the line is high whenever `busy` is low;
- the line is low one cycle after a break request is seen;
- the line is high on the cycle after break release;
- the final stop bit is high;
- `busy` stays high under a sustained flow hold.

Other properties can only be shown by the bench's scenarios, which compare each bit position at mid-bit against a frame the bench builds itself. These are bit order, parity value for each mode, stop-bit count, exact bit length, and the full guard interval after break. The same applies to completion of a character when flow control drops mid-frame, immunity to a mid-frame setup change, and the effect of the flow-disable bit.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int CFG_W        = 31;
  localparam int DIV_W        = 24;
  localparam int BYTE_W       = 8;
  localparam int CNT_W        = 4;
  localparam int POS_PAR_SEL  = 24;
  localparam int POS_PAR_FIX  = 25;
  localparam int POS_PAR_EN   = 26;
  localparam int POS_STOP2    = 27;
  localparam int POS_LEN_LO   = 28;
  localparam int POS_FLOW_OFF = 30;
  localparam int FMT_W        = POS_FLOW_OFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK, ST_GUARD
  } tx_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] nbits;
    logic             stop2;
    logic             par_en;
    logic             par_fix;
    logic             par_sel;
  } frame_fmt_t;

  // Clocks per bit; zero is promoted to one.
  function automatic logic [DIV_W-1:0] bit_period(input logic [FMT_W-1:0] c);
    logic [DIV_W-1:0] d;
    d = c[DIV_W-1:0];
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  function automatic frame_fmt_t decode_fmt(input logic [FMT_W-1:0] c);
    frame_fmt_t f;
    f.nbits   = CNT_W'(BYTE_W) - {2'b00, c[POS_LEN_LO+1:POS_LEN_LO]};
    f.stop2   = c[POS_STOP2];
    f.par_en  = c[POS_PAR_EN];
    f.par_fix = c[POS_PAR_FIX];
    f.par_sel = c[POS_PAR_SEL];
    return f;
  endfunction

  // Parity over the first nbits data bits; par_sel picks odd when not forced.
  function automatic logic parity_of(input frame_fmt_t f, input logic [BYTE_W-1:0] d);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < BYTE_W; i++)
      if (i < int'(f.nbits)) acc ^= d[i];
    return f.par_fix ? f.par_sel : (acc ^ f.par_sel);
  endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] period,
  output logic         bit_end
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= period - W'(1);
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign bit_end = (cnt == '0);
endmodule

// File: rtl/tx_cts_sync.sv
module tx_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_in,
  output logic cts_n_sync
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= cts_n_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], cts_n_in};
      end
    end
  endgenerate

  assign cts_n_sync = sr[STAGES-1];
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import serial_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FMT_W-1:0]  cfg_fmt,
  input  logic              start,
  input  logic [BYTE_W-1:0] send_byte,
  input  logic              brk_req,
  input  logic              bit_end,
  output logic              tmr_load,
  output logic [DIV_W-1:0]  tmr_period,
  output logic              line_out,
  output logic              idle,
  output logic              frame_done
);
  tx_state_e         st, st_n;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bits_left;
  logic              stop_left;
  logic              par_bit;
  frame_fmt_t        fmt;
  logic [DIV_W-1:0]  per;

  frame_fmt_t        live_fmt;
  logic [DIV_W-1:0]  live_per;
  logic              last_data;

  assign live_fmt  = decode_fmt(cfg_fmt);
  assign live_per  = bit_period(cfg_fmt);
  assign last_data = (bits_left == CNT_W'(1));

  always_comb begin
    st_n       = st;
    tmr_load   = 1'b0;
    tmr_period = per;
    unique case (st)
      ST_IDLE: if (start) begin
        st_n = ST_START; tmr_load = 1'b1; tmr_period = live_per;
      end
      ST_START: if (bit_end) begin
        st_n = ST_DATA; tmr_load = 1'b1;
      end
      ST_DATA: if (bit_end) begin
        tmr_load = 1'b1;
        if (last_data) st_n = fmt.par_en ? ST_PAR : ST_STOP;
      end
      ST_PAR: if (bit_end) begin
        st_n = ST_STOP; tmr_load = 1'b1;
      end
      ST_STOP: if (bit_end) begin
        if (stop_left) tmr_load = 1'b1;
        else           st_n = ST_IDLE;
      end
      ST_BRK: if (!brk_req) begin
        st_n = ST_GUARD; tmr_load = 1'b1; tmr_period = live_per;
      end
      ST_GUARD: if (bit_end) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    if (brk_req && st != ST_BRK) begin
      st_n     = ST_BRK;
      tmr_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      shreg     <= '0;
      bits_left <= '0;
      stop_left <= 1'b0;
      par_bit   <= 1'b1;
      fmt       <= '0;
      per       <= DIV_W'(1);
    end else begin
      st <= st_n;
      if (st == ST_IDLE && st_n == ST_START) begin
        shreg     <= send_byte;
        bits_left <= live_fmt.nbits;
        stop_left <= live_fmt.stop2;
        par_bit   <= parity_of(live_fmt, send_byte);
        fmt       <= live_fmt;
        per       <= live_per;
      end else if (st == ST_DATA && bit_end) begin
        shreg     <= {1'b0, shreg[BYTE_W-1:1]};
        bits_left <= bits_left - CNT_W'(1);
      end else if (st == ST_STOP && bit_end && stop_left) begin
        stop_left <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_START: line_out = 1'b0;
      ST_DATA:  line_out = shreg[0];
      ST_PAR:   line_out = par_bit;
      ST_BRK:   line_out = 1'b0;
      default:  line_out = 1'b1;
    endcase
  end

  assign idle       = (st == ST_IDLE);
  assign frame_done = (st == ST_STOP) && bit_end && !stop_left && !brk_req;
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              send_req,
  input  logic [BYTE_W-1:0] send_byte,
  input  logic              cts_n,
  input  logic              brk_req,
  output logic              busy,
  output logic              line_out
);
  logic             cts_n_sync;
  logic             flow_ok;
  logic             seq_idle;
  logic             accept;
  logic             frame_done;
  logic             bit_end;
  logic             tmr_load;
  logic [DIV_W-1:0] tmr_period;

  tx_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_n_in   (cts_n),
    .cts_n_sync (cts_n_sync)
  );

  assign flow_ok = cfg_word[POS_FLOW_OFF] || !cts_n_sync;
  assign busy    = !seq_idle || brk_req || !flow_ok;
  assign accept  = send_req && !busy;

  tx_bit_timer #(.W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .period  (tmr_period),
    .bit_end (bit_end)
  );

  tx_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_fmt    (cfg_word[FMT_W-1:0]),
    .start      (accept),
    .send_byte  (send_byte),
    .brk_req    (brk_req),
    .bit_end    (bit_end),
    .tmr_load   (tmr_load),
    .tmr_period (tmr_period),
    .line_out   (line_out),
    .idle       (seq_idle),
    .frame_done (frame_done)
  );
endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic flow_off,
  input logic cts_n,
  input logic brk_req,
  input logic busy,
  input logic line_out,
  input logic accept,
  input logic frame_done
);
  logic       past_ok;
  logic [3:0] cts_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok    <= 1'b0;
      cts_hi_cnt <= '0;
    end else begin
      past_ok <= 1'b1;
      if (!cts_n)                    cts_hi_cnt <= '0;
      else if (cts_hi_cnt != 4'hF)   cts_hi_cnt <= cts_hi_cnt + 4'd1;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R1

  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_off && int'(cts_hi_cnt) > SYNC_STAGES) |-> busy); // R2

  AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(brk_req)) |-> !line_out); // R4

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_out); // R5

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !line_out); // R5

  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> line_out); // R7

  AST_GUARD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(brk_req) && !brk_req) |=> line_out); // R10
endmodule

bind serial_tx serial_tx_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flow_off   (cfg_word[serial_tx_pkg::POS_FLOW_OFF]),
  .cts_n      (cts_n),
  .brk_req    (brk_req),
  .busy       (busy),
  .line_out   (line_out),
  .accept     (accept),
  .frame_done (frame_done)
);

// File: tb/sim_serial_tx.sv
`timescale 1ns/1ps
module sim_serial_tx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [30:0] cfg_word;
  logic        send_req;
  logic [7:0]  send_byte;
  logic        cts_n;
  logic        brk_req;
  logic        busy;
  logic        line_out;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .send_req(send_req),
    .send_byte(send_byte), .cts_n(cts_n), .brk_req(brk_req),
    .busy(busy), .line_out(line_out)
  );

  // {cfg[30:0], data[7:0]}
  localparam logic [38:0] VEC [6] = '{
    {31'h0000_0004, 8'hA5},  // 8 bits, no parity, 1 stop
    {31'h1400_0003, 8'h5B},  // 7 bits, even parity
    {31'h3D00_0005, 8'h13},  // 5 bits, odd parity, 2 stop
    {31'h2700_0002, 8'hFF},  // 6 bits, forced 1 parity
    {31'h0E00_0000, 8'h81},  // divisor 0 -> 1, forced 0 parity, 2 stop
    {31'h0D00_0007, 8'h00}   // 8 bits, odd parity, 2 stop
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [30:0] c, input logic [7:0] d,
                                    output logic [15:0] b, output int n);
    int nb;
    logic p;
    nb = 8 - int'(c[29:28]);
    b = '1;
    n = 0;
    b[n] = 1'b0; n++;
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      b[n] = d[i]; n++;
      p = p ^ d[i];
    end
    if (c[26]) begin
      b[n] = c[25] ? c[24] : (c[24] ? ~p : p);
      n++;
    end
    b[n] = 1'b1; n++;
    if (c[27]) begin b[n] = 1'b1; n++; end
  endfunction

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  // mode 0: plain, 1: raise cts_n mid-frame, 2: change cfg mid-frame
  task automatic run_frame(input logic [30:0] c, input logic [7:0] d,
                           input int mode, input string req);
    logic [15:0] eb;
    int n, dv, cur, bad;
    logic gotv, expv;
    exp_frame(c, d, eb, n);
    dv = (c[23:0] == 24'd0) ? 1 : int'(c[23:0]);
    cfg_word = c;
    @(negedge clk);
    wait_idle();
    send_req = 1'b1; send_byte = d;
    @(posedge clk);
    @(negedge clk);
    send_req = 1'b0; send_byte = 8'h00;
    cur = 0;
    chk(busy === 1'b1, req, "busy after accept", 32'(busy), 32'd1);
    bad = 0; gotv = 1'b0; expv = 1'b0;
    for (int j = 0; j < n; j++) begin
      while (cur < j*dv + dv/2) begin
        @(posedge clk); @(negedge clk); cur++;
        if (mode == 1 && cur == 2*dv) cts_n = 1'b1;
        if (mode == 2 && cur == 2*dv) cfg_word = 31'h3F00_0001;
      end
      if (line_out !== eb[j] && bad == 0) begin
        bad = j + 1; gotv = line_out; expv = eb[j];
      end
    end
    chk(bad == 0, req, $sformatf("frame bit %0d", bad - 1), 32'(gotv), 32'(expv));
    while (cur < n*dv - 1) begin @(posedge clk); @(negedge clk); cur++; end
    chk(busy === 1'b1, req, "busy in last stop cycle", 32'(busy), 32'd1);
    @(posedge clk); @(negedge clk);
    if (mode == 1) begin
      chk(busy === 1'b1 && line_out === 1'b1, req, "held after frame (busy,line)",
          {30'd0, busy, line_out}, 32'd3);
    end else begin
      chk(busy === 1'b0 && line_out === 1'b1, req, "idle after frame (busy,line)",
          {30'd0, busy, line_out}, 32'd1);
    end
  endtask

  initial begin
    int lows, bad;
    rst_n = 1'b0; cfg_word = 31'h0000_0004; send_req = 1'b0; send_byte = 8'h00;
    cts_n = 1'b0; brk_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(line_out === 1'b1, "R5", "reset line level", 32'(line_out), 32'd1);
    chk(busy === 1'b0, "R1", "reset busy", 32'(busy), 32'd0);

    for (int i = 0; i < 6; i++)
      run_frame(VEC[i][38:8], VEC[i][7:0], 0, "R5_R6_R7_R8");

    // R2: flow hold blocks new characters
    cfg_word = 31'h0000_0004; cts_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b1, "R2", "busy under cts hold", 32'(busy), 32'd1);
    send_req = 1'b1; send_byte = 8'h00;
    lows = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 2) send_req = 1'b0;
      if (line_out !== 1'b1) lows++;
    end
    chk(lows == 0, "R2", "low cycles while held", 32'(lows), 32'd0);
    cts_n = 1'b0;
    run_frame(31'h0000_0004, 8'h96, 0, "R2");

    // R3: flow control disabled ignores cts_n
    cts_n = 1'b1;
    repeat (4) @(negedge clk);
    run_frame(31'h4000_0003, 8'h3C, 0, "R3");
    cts_n = 1'b0;
    repeat (4) @(negedge clk);

    // R9: cts_n rises mid-character
    run_frame(31'h0000_0003, 8'hC6, 1, "R9");
    cts_n = 1'b0;
    repeat (4) @(negedge clk);

    // R11: setup change mid-character
    run_frame(31'h1400_0004, 8'h77, 2, "R11");

    // R4: break aborts a character and holds the line low
    cfg_word = 31'h0000_0006;
    @(negedge clk);
    wait_idle();
    send_req = 1'b1; send_byte = 8'h55;
    @(posedge clk); @(negedge clk);
    send_req = 1'b0;
    repeat (8) @(negedge clk);
    brk_req = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(line_out === 1'b0, "R4", "line after break request", 32'(line_out), 32'd0);
    chk(busy === 1'b1, "R4", "busy during break", 32'(busy), 32'd1);
    send_req = 1'b1;
    lows = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (line_out !== 1'b0 || busy !== 1'b1) lows++;
    end
    send_req = 1'b0;
    chk(lows == 0, "R4", "cycles not held low during break", 32'(lows), 32'd0);

    // R10: guard interval after break release
    brk_req = 1'b0;
    @(posedge clk);
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (line_out !== 1'b1 || busy !== 1'b1) bad++;
      @(posedge clk);
    end
    chk(bad == 0, "R10", "guard cycles not high/busy", 32'(bad), 32'd0);
    @(negedge clk);
    chk(busy === 1'b0, "R10", "busy after guard", 32'(busy), 32'd0);
    run_frame(31'h0000_0006, 8'h3A, 0, "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule